// File: doc/BRIEF.md
# Stream Rate Regulator

This block sits on the sending side of a data-streaming link. It keeps a transmit rate and an on/off gate for each stream in a fixed table. The far end sends back flow-control commands, and this block applies them to that state. Each command picks its targets in one of three ways: one stream by index, every stream whose configured group number matches, or every stream on the port. The command then turns the gate on, turns it off, raises the rate by a fraction of itself, lowers it by a fraction of itself, or does nothing.

Each stream has a token accumulator. While the stream's gate is on, the accumulator adds the stream's rate every clock. When it holds at least one token, the stream is allowed to send one word. The downstream sender reports each word it actually sends, and that removes one token. Rates run on an 8-bit scale, so 255 is the highest rate.

Top module: `srr_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every stream has rate `INIT_RATE` (default 128), its gate is on (`stream_en` = 1), and `send_ok` is 0.
- R2: Scope code 0 (single) targets only the stream whose index equals `cmd_target`. A `cmd_target` of `NUM_STREAMS` or more targets nothing.
- R3: Scope code 1 (group) targets every stream whose 4-bit field in `group_id_cfg` (bits 4i+3..4i for stream i) equals `cmd_target`. A group number that no stream holds changes nothing.
- R4: Scope code 2 targets all streams. Scope code 3 targets nothing.
- R5: Op code 2 turns off the gate of every targeted stream and leaves its rate unchanged. Op code 1 turns the gate back on.
- R6: Op code 4 sets the rate to r − floor(r·k/255), where k is `cmd_frac`. The result is never allowed below 1.
- R7: Op code 3 sets the rate to r + floor(r·k/255), capped at 255.
- R8: Op code 0, the unused op codes 5 to 7, and any cycle with `cmd_valid` low change neither rates nor gates.
- R9: Each stream has a 16-bit accumulator, cleared by reset, that adds the stream's rate on every clock while its gate is on. It holds its value while the gate is off, and it saturates at 65535. `send_ok` is 1 when the gate is on and the accumulator is 256 or more. A clock with both `send_ok` and `send_take` high removes 256.
- R10: A command presented in one cycle shows up at the outputs after the next rising edge. Commands presented on back-to-back cycles are applied one per cycle, in the order they arrive. The accumulator update on that same edge uses the rate and gate from before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Flow-control command present this cycle |
| cmd_scope | input | 2 | 0 single, 1 group, 2 all, 3 none |
| cmd_op | input | 3 | 0 no change, 1 gate on, 2 gate off, 3 increase, 4 decrease |
| cmd_target | input | 4 | Stream index or group number |
| cmd_frac | input | 8 | Fraction numerator k, taken over 255 |
| group_id_cfg | input | NUM_STREAMS*4 | Configured group number of each stream |
| send_take | input | NUM_STREAMS | Sender used one word of permission |
| stream_en | output | NUM_STREAMS | Gate state of each stream |
| send_ok | output | NUM_STREAMS | Permission to send one word |
| rate_o | output | NUM_STREAMS*8 | Current rate of each stream |

## Verification
The bench probes where rates clamp. A full decrease from a rate of 1 must land on 1, not 0; a design that let it reach 0 would leave the stream stuck forever. An increase past 255 must cap at 255; without the cap the value would wrap to a small number. Selection corner cases are covered too: a stream index outside the table, a group that nobody belongs to, scope code 3, and unused op codes. Each of these would wrongly change state if the decoder were too loose. For the accumulator, the bench checks the exact edge where a token appears after reset. It checks that the count is held, not grown, while the gate is off; a design that kept adding would grant permission early after the gate reopens. Finally, it drains a saturated accumulator at rate 1 and expects exactly 256 grants. A count that wrapped past 65535 would give far fewer.

// File: rtl/srr_pkg.sv
package srr_pkg;

    localparam int RATE_W  = 8;
    localparam int FRAC_W  = 8;
    localparam int GRP_W   = 4;
    localparam int ACC_W   = 16;
    localparam int TOKEN   = 256;
    localparam int RATE_MAX = (1 << RATE_W) - 1;
    localparam int PROD_W  = RATE_W + FRAC_W;

    typedef enum logic [1:0] {
        SCOPE_ONE   = 2'd0,
        SCOPE_GROUP = 2'd1,
        SCOPE_ALL   = 2'd2,
        SCOPE_NONE  = 2'd3
    } scope_e;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_XON   = 3'd1,
        OP_XOFF  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4,
        OP_RSV5  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef logic [RATE_W-1:0] rate_t;

    typedef struct packed {
        scope_e             scope;
        op_e                op;
        logic [GRP_W-1:0]   target;
        logic [FRAC_W-1:0]  frac;
    } flow_cmd_t;

    // Fraction of the current rate: floor(r * k / 255)
    function automatic rate_t rate_portion(rate_t r, logic [FRAC_W-1:0] k);
        logic [PROD_W-1:0] prod;
        logic [PROD_W-1:0] quot;
        prod = {{FRAC_W{1'b0}}, r} * {{RATE_W{1'b0}}, k};
        quot = prod / PROD_W'(RATE_MAX);
        return quot[RATE_W-1:0];
    endfunction

    function automatic rate_t rate_raise(rate_t r, logic [FRAC_W-1:0] k);
        logic [RATE_W:0] sum;
        sum = {1'b0, r} + {1'b0, rate_portion(r, k)};
        return sum[RATE_W] ? rate_t'(RATE_MAX) : sum[RATE_W-1:0];
    endfunction

    function automatic rate_t rate_lower(rate_t r, logic [FRAC_W-1:0] k);
        rate_t diff;
        diff = r - rate_portion(r, k);
        return (diff == '0) ? rate_t'(1) : diff;
    endfunction

endpackage

// File: rtl/srr_cmd_decode.sv
module srr_cmd_decode
    import srr_pkg::*;
#(
    parameter int NUM_STREAMS = 8
) (
    input  logic                         cmd_valid,
    input  flow_cmd_t                    cmd,
    input  logic [NUM_STREAMS*GRP_W-1:0] group_id_cfg,
    output logic [NUM_STREAMS-1:0]       hit
);

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_sel
        logic [GRP_W-1:0] gid;
        assign gid = group_id_cfg[i*GRP_W +: GRP_W];

        always_comb begin
            hit[i] = 1'b0;
            if (cmd_valid) begin
                case (cmd.scope)
                    SCOPE_ONE:   hit[i] = (cmd.target == GRP_W'(i));
                    SCOPE_GROUP: hit[i] = (cmd.target == gid);
                    SCOPE_ALL:   hit[i] = 1'b1;
                    default:     hit[i] = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/srr_rate_cell.sv
module srr_rate_cell
    import srr_pkg::*;
#(
    parameter rate_t INIT_RATE = rate_t'(128)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  op_e               op,
    input  logic [FRAC_W-1:0] frac,
    output rate_t             rate,
    output logic              en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate <= INIT_RATE;
            en   <= 1'b1;
        end else if (hit) begin
            case (op)
                OP_XON:  en   <= 1'b1;
                OP_XOFF: en   <= 1'b0;
                OP_INC:  rate <= rate_raise(rate, frac);
                OP_DEC:  rate <= rate_lower(rate, frac);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/srr_token_acc.sv
module srr_token_acc
    import srr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  rate_t rate,
    input  logic  take,
    output logic  ok
);

    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc;
    logic [SUM_W-1:0] sum;

    assign ok = en && (acc >= ACC_W'(TOKEN));

    always_comb begin
        sum = {1'b0, acc} + (en ? SUM_W'(rate) : SUM_W'(0));
        if (take && ok) begin
            sum = sum - SUM_W'(TOKEN);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (sum[ACC_W]) begin
            acc <= '1;
        end else begin
            acc <= sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/srr_top.sv
module srr_top
    import srr_pkg::*;
#(
    parameter int    NUM_STREAMS = 8,
    parameter rate_t INIT_RATE   = rate_t'(128)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid,
    input  logic [1:0]                    cmd_scope,
    input  logic [2:0]                    cmd_op,
    input  logic [3:0]                    cmd_target,
    input  logic [7:0]                    cmd_frac,
    input  logic [NUM_STREAMS*4-1:0]      group_id_cfg,
    input  logic [NUM_STREAMS-1:0]        send_take,
    output logic [NUM_STREAMS-1:0]        stream_en,
    output logic [NUM_STREAMS-1:0]        send_ok,
    output logic [NUM_STREAMS*8-1:0]      rate_o
);

    flow_cmd_t              cmd;
    logic [NUM_STREAMS-1:0] hit;

    assign cmd.scope  = scope_e'(cmd_scope);
    assign cmd.op     = op_e'(cmd_op);
    assign cmd.target = cmd_target;
    assign cmd.frac   = cmd_frac;

    srr_cmd_decode #(.NUM_STREAMS(NUM_STREAMS)) dec_i (
        .cmd_valid    (cmd_valid),
        .cmd          (cmd),
        .group_id_cfg (group_id_cfg),
        .hit          (hit)
    );

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_stream
        rate_t rate_q;

        srr_rate_cell #(.INIT_RATE(INIT_RATE)) cell_i (
            .clk  (clk),
            .rst  (rst),
            .hit  (hit[i]),
            .op   (cmd.op),
            .frac (cmd.frac),
            .rate (rate_q),
            .en   (stream_en[i])
        );

        srr_token_acc acc_i (
            .clk  (clk),
            .rst  (rst),
            .en   (stream_en[i]),
            .rate (rate_q),
            .take (send_take[i]),
            .ok   (send_ok[i])
        );

        assign rate_o[i*RATE_W +: RATE_W] = rate_q;
    end

endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
    parameter int NUM_STREAMS = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cmd_valid,
    input logic [1:0]               cmd_scope,
    input logic [2:0]               cmd_op,
    input logic [NUM_STREAMS-1:0]   stream_en,
    input logic [NUM_STREAMS-1:0]   send_ok,
    input logic [NUM_STREAMS*8-1:0] rate_o
);

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_floor
        assert_rate_floor_R6: assert property (@(posedge clk) disable iff (rst)
            rate_o[i*8 +: 8] != 8'd0);
    end

    assert_ok_needs_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (send_ok & ~stream_en) == '0);

    assert_idle_rate_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(rate_o) && $stable(stream_en)));

    assert_all_gate_off_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_scope == 2'd2 && cmd_op == 3'd2) |=> (stream_en == '0));

    assert_all_gate_on_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_scope == 2'd2 && cmd_op == 3'd1) |=> (stream_en == '1));

    assert_none_scope_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_scope == 2'd3) |=> ($stable(rate_o) && $stable(stream_en)));

endmodule

bind srr_top srr_checker #(.NUM_STREAMS(NUM_STREAMS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_scope (cmd_scope),
    .cmd_op    (cmd_op),
    .stream_en (stream_en),
    .send_ok   (send_ok),
    .rate_o    (rate_o)
);

// File: tb/srr_top_tb_top.sv
module srr_top_tb_top;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cmd_valid = 1'b0;
    logic [1:0]     cmd_scope = '0;
    logic [2:0]     cmd_op = '0;
    logic [3:0]     cmd_target = '0;
    logic [7:0]     cmd_frac = '0;
    logic [N*4-1:0] group_id_cfg;
    logic [N-1:0]   send_take = '0;
    logic [N-1:0]   stream_en;
    logic [N-1:0]   send_ok;
    logic [N*8-1:0] rate_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int unsigned m_rate [N];
    bit          m_en [N];

    // {scope, op, target, frac}; applied back-to-back (R10)
    localparam logic [16:0] VEC [15] = '{
        {2'd0, 3'd2, 4'd3, 8'd0},    // R5 single gate off
        {2'd0, 3'd4, 4'd0, 8'd64},   // R2 R6 single decrease
        {2'd1, 3'd3, 4'd1, 8'd255},  // R3 R7 group 1 increase, caps
        {2'd2, 3'd4, 4'd0, 8'd128},  // R4 R6 all decrease
        {2'd3, 3'd2, 4'd0, 8'd0},    // R4 scope none
        {2'd0, 3'd1, 4'd3, 8'd0},    // R5 single gate on
        {2'd2, 3'd0, 4'd0, 8'd200},  // R8 no change
        {2'd2, 3'd6, 4'd0, 8'd200},  // R8 unused op
        {2'd0, 3'd2, 4'd9, 8'd0},    // R2 index out of range
        {2'd1, 3'd2, 4'd2, 8'd0},    // R3 group gate off
        {2'd2, 3'd4, 4'd0, 8'd255},  // R6 floor at 1
        {2'd2, 3'd3, 4'd0, 8'd255},  // R7 recover from 1
        {2'd1, 3'd3, 4'd0, 8'd200},  // R3 group increase
        {2'd2, 3'd1, 4'd0, 8'd0},    // R4 R5 all gate on
        {2'd1, 3'd4, 4'd5, 8'd100}   // R3 empty group
    };

    srr_top #(.NUM_STREAMS(N)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_scope    (cmd_scope),
        .cmd_op       (cmd_op),
        .cmd_target   (cmd_target),
        .cmd_frac     (cmd_frac),
        .group_id_cfg (group_id_cfg),
        .send_take    (send_take),
        .stream_en    (stream_en),
        .send_ok      (send_ok),
        .rate_o       (rate_o)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmd_valid = 1'b0;
        send_take = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_rate[i] = 128;
            m_en[i] = 1'b1;
        end
    endtask

    task automatic drive(logic [16:0] v);
        cmd_valid  = 1'b1;
        cmd_scope  = v[16:15];
        cmd_op     = v[14:12];
        cmd_target = v[11:8];
        cmd_frac   = v[7:0];
    endtask

    function automatic logic [63:0] model_rates();
        logic [63:0] r = '0;
        for (int i = 0; i < N; i++) r[i*8 +: 8] = 8'(m_rate[i]);
        return r;
    endfunction

    function automatic logic [63:0] model_ens();
        logic [63:0] e = '0;
        for (int i = 0; i < N; i++) e[i] = m_en[i];
        return e;
    endfunction

    task automatic model_apply(logic [16:0] v);
        for (int i = 0; i < N; i++) begin
            bit sel;
            int unsigned part;
            case (v[16:15])
                2'd0: sel = (v[11:8] == 4'(i));
                2'd1: sel = (v[11:8] == group_id_cfg[i*4 +: 4]);
                2'd2: sel = 1'b1;
                default: sel = 1'b0;
            endcase
            if (sel) begin
                part = (m_rate[i] * v[7:0]) / 255;
                case (v[14:12])
                    3'd1: m_en[i] = 1'b1;
                    3'd2: m_en[i] = 1'b0;
                    3'd3: m_rate[i] = (m_rate[i] + part > 255) ? 255 : m_rate[i] + part;
                    3'd4: m_rate[i] = (m_rate[i] - part < 1) ? 1 : m_rate[i] - part;
                    default: ;
                endcase
            end
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) group_id_cfg[i*4 +: 4] = 4'(i % 3);
    end

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int grants;
        // R1 reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 gate", 64'(stream_en), 64'hFF);
        check("R1 rate", rate_o, {8{8'd128}});
        check("R1 send_ok", 64'(send_ok), 64'h0);

        // R9 token timing
        do_reset();
        check("R9 no token at start", 64'(send_ok[0]), 64'd0);
        tick();
        check("R9 one step 128", 64'(send_ok[0]), 64'd0);
        tick();
        check("R9 reaches 256", 64'(send_ok[0]), 64'd1);
        send_take[0] = 1'b1;
        tick();
        check("R9 take removes token", 64'(send_ok[0]), 64'd0);
        tick();
        check("R9 refill", 64'(send_ok[0]), 64'd1);
        send_take = '0;

        // R5 R9 accumulator held while gate off
        do_reset();
        drive({2'd0, 3'd2, 4'd0, 8'd0});
        tick();
        cmd_valid = 1'b0;
        check("R5 gate off", 64'(stream_en[0]), 64'd0);
        check("R5 rate kept", 64'(rate_o[7:0]), 64'd128);
        repeat (10) tick();
        check("R9 gated no permission", 64'(send_ok[1:0]), 64'b10);
        drive({2'd0, 3'd1, 4'd0, 8'd0});
        tick();
        cmd_valid = 1'b0;
        check("R9 held count after gate on", 64'(send_ok[0]), 64'd0);
        tick();
        check("R9 resume count", 64'(send_ok[0]), 64'd1);

        // Vector table, commands back-to-back (R10)
        do_reset();
        foreach (VEC[k]) begin
            drive(VEC[k]);
            model_apply(VEC[k]);
            tick();
            check($sformatf("R10 vec%0d rates", k), rate_o, model_rates());
            check($sformatf("R10 vec%0d gates", k), 64'(stream_en), model_ens());
        end
        cmd_valid = 1'b0;

        // R9 saturation: drain at rate 1 gives exactly 256 grants
        do_reset();
        drive({2'd2, 3'd3, 4'd0, 8'd255});
        tick();
        cmd_valid = 1'b0;
        check("R7 cap 255", 64'(rate_o[7:0]), 64'd255);
        repeat (400) tick();
        drive({2'd2, 3'd4, 4'd0, 8'd255});
        tick();
        cmd_valid = 1'b0;
        check("R6 floor 1", 64'(rate_o[7:0]), 64'd1);
        send_take[0] = 1'b1;
        grants = 0;
        while (send_ok[0] && grants < 1000) begin
            grants++;
            tick();
        end
        send_take = '0;
        check("R9 saturated drain", 64'(grants), 64'd256);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule